// File: doc/BRIEF.md
# Power-Save Mode and Oscillator Controller

This block runs the power-save state machine of a small controller's clock unit. Software writes a configuration word that holds a 2-bit power-save mode, an oscillator-off bit, a sub-clock choice bit and a calibration-clock choice bit. A standby request then puts the block into the selected low-power state, and a wake-up event brings it back to RUN. The block decides when the main oscillator is enabled and which source feeds the CPU: the main oscillator, the sub oscillator or the ring oscillator. It also tracks oscillator stabilization with a counter of parameterized length and gates the main-oscillator clock to the watch-timer and display-driver logic.

While the CPU is on a sub clock, a request for a mode that needs the main clock is turned into the deepest watch state. The oscillator-off bit controls whether the oscillator is restarted after release and whether the CPU is moved back to the main oscillator. Clocks appear only as select codes. Analog behaviour and glitch-free switching belong to other blocks.

Top module: `pwrsave_ctl`

## Requirements
- R1: After reset, cur_state is RUN (code 0), osc_en is 0, cpu_clk_sel is ring (code 2), and osc_stable, periph_main_en, cal_clk_sel and wake_ack are 0. The internal oscillator-off bit resets to 1 and the sub-choice bit to 0.
- R2: In RUN with the CPU on the main clock (cpu_clk_sel 0), a standby_req moves cur_state on the next edge according to the stored mode. Mode 00 gives IDLE (1), 01 gives STOP (2), 10 gives WATCH (3) and 11 gives SUBW (4).
- R3: If the stored mode is 00 or 10 and cpu_clk_sel is not 0 when standby_req arrives, the block enters SUBW (4).
- R4: While the block is in SUBW, osc_en is 0. On entry, cpu_clk_sel becomes 1 (sub oscillator) when the sub-choice bit is 1 and 2 (ring oscillator) when it is 0.
- R5: A wake-up from SUBW with the oscillator-off bit at 0 moves the block to WAIT (5) with osc_en 1 and cpu_clk_sel unchanged. One cycle after osc_stable rises, the block returns to RUN and cpu_clk_sel becomes 0.
- R6: A wake-up from SUBW with the oscillator-off bit at 1 returns the block directly to RUN with osc_en 0 and the sub clock still selected.
- R7: In WATCH with the oscillator-off bit at 0, osc_en stays 1 throughout. A wake-up returns the block directly to RUN with cpu_clk_sel 0.
- R8: In WATCH with the oscillator-off bit at 1, osc_en is 0. A wake-up clears the bit, sets osc_en and enters WAIT (5). The block then returns to RUN one cycle after osc_stable rises, and the oscillator stays enabled.
- R9: osc_stable rises exactly STAB_CYCLES cycles after osc_en rises. It clears on the same edge that osc_en falls, and the count starts again from zero each time the oscillator is enabled.
- R10: In RUN, a cfg_we write takes effect on the next edge. Setting the oscillator-off bit drops osc_en on that edge and clearing it raises osc_en. cpu_clk_sel changes only through clk_sel_we, which accepts codes 0 (main), 1 (sub) and 2 (ring) and ignores code 3.
- R11: cfg_we and clk_sel_we are ignored in every state other than RUN.
- R12: wake_ack is a one-cycle pulse that occurs exactly on the edge where the block returns to RUN. A wake_evt while already in RUN has no effect.
- R13: periph_main_en is 1 only while osc_en and osc_stable are both 1 and the state is not STOP. It falls on the same edge as osc_en and rises one cycle after osc_stable.
- R14: cal_clk_sel follows the calibration-clock choice bit of the last accepted configuration write. A value of 0 means the peripheral clock and 1 means the main oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Power-save mode to store |
| cfg_osc_off | input | 1 | Oscillator-off bit to store |
| cfg_sub_sel | input | 1 | Sub-clock choice: 0 ring, 1 sub oscillator |
| cfg_cal_sel | input | 1 | Calibration clock choice to store |
| clk_sel_we | input | 1 | CPU clock-select write strobe |
| clk_sel_wdata | input | 2 | CPU clock-select code to write |
| standby_req | input | 1 | Request to enter the stored power-save mode |
| wake_evt | input | 1 | Wake-up event |
| osc_en | output | 1 | Main oscillator enable |
| osc_stable | output | 1 | Stabilization time elapsed |
| cpu_clk_sel | output | 2 | CPU clock source: 0 main, 1 sub, 2 ring |
| cal_clk_sel | output | 1 | Calibration timer clock choice |
| periph_main_en | output | 1 | Main-clock gate for watch timer and display driver |
| wake_ack | output | 1 | One-cycle pulse on return to RUN |
| cur_state | output | 3 | State code: 0 RUN, 1 IDLE, 2 STOP, 3 WATCH, 4 SUBW, 5 WAIT |

## Verification
The mode field is tried with all four codes while the CPU runs on the main clock, which shows that each code reaches its own state. IDLE and WATCH are then requested while the CPU is on the sub oscillator and on the ring oscillator, which separates the redirect into SUBW from a plain entry. Each watch state is released once with the oscillator-off bit clear and once with it set. These four cases tell a direct return apart from a wait for stabilization, and show whether the CPU returns to the main clock or stays on a sub clock. Writes made during sleep, clock-select code 3 and a wake-up seen in RUN are applied to show that they change nothing at the ports.

// File: rtl/pwrsave_pkg.sv
package pwrsave_pkg;
  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_STOP  = 2'd1,
    MD_WATCH = 2'd2,
    MD_SUBW  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CK_MAIN = 2'd0,
    CK_SUB  = 2'd1,
    CK_RING = 2'd2
  } clksel_e;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_STOP  = 3'd2,
    ST_WATCH = 3'd3,
    ST_SUBW  = 3'd4,
    ST_WAIT  = 3'd5
  } state_e;
endpackage

// File: rtl/pwrsave_stab.sv
// Stabilization timer: restarts whenever the oscillator is (re)enabled.
module pwrsave_stab #(
  parameter int STAB_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en_q,
  input  logic osc_en_d,
  output logic stable_o
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst || !osc_en_d) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else if (osc_en_q && !stb_q) begin
      if (cnt_q == LAST) stb_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stable_o = stb_q;
endmodule

// File: rtl/pwrsave_fsm.sv
// Mode state machine with configuration and clock-select registers.
module pwrsave_fsm
  import pwrsave_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_osc_off,
  input  logic       cfg_sub_sel,
  input  logic       cfg_cal_sel,
  input  logic       clk_sel_we,
  input  logic [1:0] clk_sel_wdata,
  input  logic       standby_req,
  input  logic       wake_evt,
  input  logic       stable_i,
  output state_e     state_o,
  output logic       osc_en_o,
  output logic       osc_en_next_o,
  output logic [1:0] cpu_sel_o,
  output logic       cal_sel_o,
  output logic       periph_en_o,
  output logic       wake_ack_o
);
  state_e  st_q, st_d;
  mode_e   mode_q, mode_d;
  clksel_e cpu_q, cpu_d;
  logic    off_q, off_d, sub_q, sub_d, cal_q, cal_d;
  logic    osc_q, osc_d, per_q, per_d, ack_q, ack_d;
  clksel_e sub_code;

  assign sub_code = sub_q ? CK_SUB : CK_RING;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    cpu_d  = cpu_q;
    off_d  = off_q;
    sub_d  = sub_q;
    cal_d  = cal_q;
    ack_d  = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (cfg_we) begin
          mode_d = mode_e'(cfg_mode);
          off_d  = cfg_osc_off;
          sub_d  = cfg_sub_sel;
          cal_d  = cfg_cal_sel;
        end
        if (clk_sel_we && clk_sel_wdata != 2'b11)
          cpu_d = clksel_e'(clk_sel_wdata);
        if (standby_req) begin
          unique case (mode_q)
            MD_IDLE:  st_d = (cpu_q == CK_MAIN) ? ST_IDLE : ST_SUBW;
            MD_STOP:  st_d = ST_STOP;
            MD_WATCH: st_d = (cpu_q == CK_MAIN) ? ST_WATCH : ST_SUBW;
            default:  st_d = ST_SUBW;
          endcase
          if (st_d == ST_SUBW) cpu_d = sub_code;
        end
      end
      ST_IDLE, ST_STOP: begin
        if (wake_evt) begin
          st_d  = ST_RUN;
          ack_d = 1'b1;
        end
      end
      ST_WATCH: begin
        if (wake_evt) begin
          if (off_q) begin
            off_d = 1'b0;
            st_d  = ST_WAIT;
          end else begin
            st_d  = ST_RUN;
            ack_d = 1'b1;
          end
        end
      end
      ST_SUBW: begin
        if (wake_evt) begin
          if (off_q) begin
            st_d  = ST_RUN;
            ack_d = 1'b1;
          end else begin
            st_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (stable_i) begin
          st_d  = ST_RUN;
          cpu_d = CK_MAIN;
          ack_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
    osc_d = !off_d && (st_d != ST_SUBW);
    per_d = osc_d && stable_i && (st_d != ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      mode_q <= MD_IDLE;
      cpu_q  <= CK_RING;
      off_q  <= 1'b1;
      sub_q  <= 1'b0;
      cal_q  <= 1'b0;
      osc_q  <= 1'b0;
      per_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cpu_q  <= cpu_d;
      off_q  <= off_d;
      sub_q  <= sub_d;
      cal_q  <= cal_d;
      osc_q  <= osc_d;
      per_q  <= per_d;
      ack_q  <= ack_d;
    end
  end

  assign state_o       = st_q;
  assign osc_en_o      = osc_q;
  assign osc_en_next_o = rst ? 1'b0 : osc_d;
  assign cpu_sel_o     = cpu_q;
  assign cal_sel_o     = cal_q;
  assign periph_en_o   = per_q;
  assign wake_ack_o    = ack_q;
endmodule

// File: rtl/pwrsave_ctl.sv
module pwrsave_ctl
  import pwrsave_pkg::*;
#(
  parameter int STAB_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_osc_off,
  input  logic       cfg_sub_sel,
  input  logic       cfg_cal_sel,
  input  logic       clk_sel_we,
  input  logic [1:0] clk_sel_wdata,
  input  logic       standby_req,
  input  logic       wake_evt,
  output logic       osc_en,
  output logic       osc_stable,
  output logic [1:0] cpu_clk_sel,
  output logic       cal_clk_sel,
  output logic       periph_main_en,
  output logic       wake_ack,
  output logic [2:0] cur_state
);
  state_e st;
  logic   osc_next;

  pwrsave_fsm fsm_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_osc_off(cfg_osc_off),
    .cfg_sub_sel(cfg_sub_sel), .cfg_cal_sel(cfg_cal_sel),
    .clk_sel_we(clk_sel_we), .clk_sel_wdata(clk_sel_wdata),
    .standby_req(standby_req), .wake_evt(wake_evt),
    .stable_i(osc_stable),
    .state_o(st), .osc_en_o(osc_en), .osc_en_next_o(osc_next),
    .cpu_sel_o(cpu_clk_sel), .cal_sel_o(cal_clk_sel),
    .periph_en_o(periph_main_en), .wake_ack_o(wake_ack)
  );

  pwrsave_stab #(.STAB_CYCLES(STAB_CYCLES)) stab_i (
    .clk(clk), .rst(rst),
    .osc_en_q(osc_en), .osc_en_d(osc_next),
    .stable_o(osc_stable)
  );

  assign cur_state = st;
endmodule

// File: rtl/pwrsave_ctl_chk.sv
module pwrsave_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [2:0] cur_state,
  input logic       osc_en,
  input logic       osc_stable,
  input logic       wake_ack,
  input logic       periph_main_en,
  input logic       cal_clk_sel,
  input logic [1:0] cpu_clk_sel
);
  // R4: oscillator held off in the deepest watch state
  a_r4_subw_osc_off: assert property (@(posedge clk) disable iff (rst)
    cur_state == 3'd4 |-> !osc_en);
  // R9: stable flag never outlives the oscillator
  a_r9_stable_needs_osc: assert property (@(posedge clk) disable iff (rst)
    osc_stable |-> osc_en);
  // R12: acknowledge lasts one cycle
  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    wake_ack |=> !wake_ack);
  // R12: acknowledge only on entry into RUN
  a_r12_ack_on_return: assert property (@(posedge clk) disable iff (rst)
    wake_ack |-> (cur_state == 3'd0) && ($past(cur_state) != 3'd0));
  // R13: peripheral gate needs a stable oscillator and no STOP
  a_r13_periph_gate: assert property (@(posedge clk) disable iff (rst)
    periph_main_en |-> osc_stable && (cur_state != 3'd2));
  // R11: configuration writes outside RUN leave the calibration choice alone
  a_r11_cfg_ignored: assert property (@(posedge clk) disable iff (rst)
    (cur_state != 3'd0) && cfg_we |=> $stable(cal_clk_sel));
  // R5: waiting state keeps the oscillator running
  a_r5_wait_osc_on: assert property (@(posedge clk) disable iff (rst)
    cur_state == 3'd5 |-> osc_en);
  // R3: WATCH is only ever held with the CPU on the main clock
  a_r3_watch_on_main: assert property (@(posedge clk) disable iff (rst)
    cur_state == 3'd3 |-> cpu_clk_sel == 2'd0);
endmodule

bind pwrsave_ctl pwrsave_ctl_chk chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cur_state(cur_state),
  .osc_en(osc_en), .osc_stable(osc_stable), .wake_ack(wake_ack),
  .periph_main_en(periph_main_en), .cal_clk_sel(cal_clk_sel),
  .cpu_clk_sel(cpu_clk_sel)
);

// File: tb/pwrsave_ctl_tb_top.sv
module pwrsave_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_osc_off = 1'b0;
  logic       cfg_sub_sel = 1'b0;
  logic       cfg_cal_sel = 1'b0;
  logic       clk_sel_we = 1'b0;
  logic [1:0] clk_sel_wdata = 2'd0;
  logic       standby_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic       osc_en, osc_stable, cal_clk_sel, periph_main_en, wake_ack;
  logic [1:0] cpu_clk_sel;
  logic [2:0] cur_state;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrsave_ctl #(.STAB_CYCLES(STAB)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_osc_off(cfg_osc_off), .cfg_sub_sel(cfg_sub_sel), .cfg_cal_sel(cfg_cal_sel),
    .clk_sel_we(clk_sel_we), .clk_sel_wdata(clk_sel_wdata),
    .standby_req(standby_req), .wake_evt(wake_evt),
    .osc_en(osc_en), .osc_stable(osc_stable), .cpu_clk_sel(cpu_clk_sel),
    .cal_clk_sel(cal_clk_sel), .periph_main_en(periph_main_en),
    .wake_ack(wake_ack), .cur_state(cur_state)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr_cfg(logic [1:0] m, logic off, logic sub, logic cal);
    cfg_mode = m; cfg_osc_off = off; cfg_sub_sel = sub; cfg_cal_sel = cal;
    cfg_we = 1'b1; step(); cfg_we = 1'b0;
  endtask

  task automatic wr_sel(logic [1:0] v);
    clk_sel_wdata = v; clk_sel_we = 1'b1; step(); clk_sel_we = 1'b0;
  endtask

  task automatic standby();
    standby_req = 1'b1; step(); standby_req = 1'b0;
  endtask

  task automatic wake();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "state", cur_state, 0);
    chk("R1", "osc_en", osc_en, 0);
    chk("R1", "cpu_sel", cpu_clk_sel, 2);
    chk("R1", "stable", osc_stable, 0);
    chk("R1", "periph", periph_main_en, 0);
    chk("R1", "cal", cal_clk_sel, 0);
    chk("R1", "ack", wake_ack, 0);
  endtask

  task automatic t_start_osc();
    wr_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    chk("R10", "osc_en after clear", osc_en, 1);
    chk("R10", "cpu unchanged", cpu_clk_sel, 2);
    step(STAB - 1);
    chk("R9", "stable early", osc_stable, 0);
    step();
    chk("R9", "stable on time", osc_stable, 1);
    chk("R13", "periph lag", periph_main_en, 0);
    step();
    chk("R13", "periph on", periph_main_en, 1);
    wr_sel(2'd3);
    chk("R10", "code 3 ignored", cpu_clk_sel, 2);
    wr_sel(2'd0);
    chk("R10", "select main", cpu_clk_sel, 0);
  endtask

  task automatic t_watch_on();
    wr_cfg(2'd2, 1'b0, 1'b0, 1'b0);
    standby();
    chk("R2", "watch entry", cur_state, 3);
    chk("R7", "osc kept", osc_en, 1);
    wr_sel(2'd2);
    chk("R11", "sel write in watch", cpu_clk_sel, 0);
    wake();
    chk("R7", "direct return", cur_state, 0);
    chk("R12", "ack", wake_ack, 1);
    chk("R7", "cpu main", cpu_clk_sel, 0);
    step();
    chk("R12", "ack one cycle", wake_ack, 0);
  endtask

  task automatic t_watch_off();
    wr_cfg(2'd2, 1'b1, 1'b0, 1'b0);
    chk("R10", "osc stops", osc_en, 0);
    chk("R9", "stable clears", osc_stable, 0);
    chk("R13", "periph off", periph_main_en, 0);
    standby();
    chk("R8", "watch entry", cur_state, 3);
    wr_cfg(2'd2, 1'b0, 1'b0, 1'b1);
    chk("R11", "cfg ignored osc", osc_en, 0);
    chk("R11", "cfg ignored cal", cal_clk_sel, 0);
    wake();
    chk("R8", "wait state", cur_state, 5);
    chk("R8", "osc restart", osc_en, 1);
    chk("R8", "no ack yet", wake_ack, 0);
    step(STAB - 1);
    chk("R9", "stable early", osc_stable, 0);
    chk("R8", "still waiting", cur_state, 5);
    step();
    chk("R9", "stable on time", osc_stable, 1);
    step();
    chk("R8", "return run", cur_state, 0);
    chk("R12", "ack", wake_ack, 1);
    chk("R8", "cpu main", cpu_clk_sel, 0);
    step();
    chk("R8", "osc stays on", osc_en, 1);
  endtask

  task automatic t_idle_stop();
    wr_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    standby();
    chk("R2", "idle entry", cur_state, 1);
    chk("R13", "periph in idle", periph_main_en, 1);
    wake();
    chk("R12", "idle return", cur_state, 0);
    chk("R12", "idle ack", wake_ack, 1);
    wr_cfg(2'd1, 1'b0, 1'b0, 1'b0);
    standby();
    chk("R2", "stop entry", cur_state, 2);
    chk("R13", "periph in stop", periph_main_en, 0);
    chk("R2", "osc in stop", osc_en, 1);
    wake();
    chk("R2", "stop return", cur_state, 0);
    chk("R13", "periph back", periph_main_en, 1);
  endtask

  task automatic t_redirect_sub();
    wr_cfg(2'd0, 1'b0, 1'b1, 1'b0);
    wr_sel(2'd1);
    chk("R10", "select sub", cpu_clk_sel, 1);
    standby();
    chk("R3", "idle redirected", cur_state, 4);
    chk("R4", "osc off", osc_en, 0);
    chk("R4", "sub osc chosen", cpu_clk_sel, 1);
    wake();
    chk("R5", "wait state", cur_state, 5);
    chk("R5", "osc on", osc_en, 1);
    chk("R5", "cpu still sub", cpu_clk_sel, 1);
    step(STAB);
    chk("R5", "cpu sub at stable", cpu_clk_sel, 1);
    step();
    chk("R5", "return run", cur_state, 0);
    chk("R5", "cpu main", cpu_clk_sel, 0);
    chk("R12", "ack", wake_ack, 1);
  endtask

  task automatic t_subw_off();
    wr_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    chk("R10", "osc off", osc_en, 0);
    standby();
    chk("R2", "subw entry", cur_state, 4);
    chk("R4", "ring chosen", cpu_clk_sel, 2);
    wake();
    chk("R6", "direct return", cur_state, 0);
    chk("R6", "ack", wake_ack, 1);
    chk("R6", "cpu ring", cpu_clk_sel, 2);
    chk("R6", "osc stays off", osc_en, 0);
  endtask

  task automatic t_watch_on_ring();
    wr_cfg(2'd2, 1'b1, 1'b0, 1'b0);
    standby();
    chk("R3", "watch redirected", cur_state, 4);
    wake();
    chk("R6", "return run", cur_state, 0);
    chk("R6", "cpu ring", cpu_clk_sel, 2);
  endtask

  task automatic t_cal_spurious();
    wr_cfg(2'd3, 1'b1, 1'b0, 1'b1);
    chk("R14", "cal main", cal_clk_sel, 1);
    wake();
    chk("R12", "wake in run state", cur_state, 0);
    chk("R12", "no ack in run", wake_ack, 0);
    chk("R12", "osc unchanged", osc_en, 0);
    wr_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    chk("R14", "cal periph", cal_clk_sel, 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    step();
    t_reset();
    t_start_osc();
    t_watch_on();
    t_watch_off();
    t_idle_stop();
    t_redirect_sub();
    t_subw_off();
    t_watch_on_ring();
    t_cal_spurious();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule